// File: doc/BRIEF.md
# SPI Queue Buffer with Status Flags

This block holds the outgoing and incoming frames of an SPI port and sits between a processor or DMA engine on one side and a serial shift engine on the other. Outgoing words go into a transmit queue of five entries. Each word carries a marker bit that tells the shift engine whether it closes the current queue. Frames that the shift engine has received go into a receive queue of five entries, and the bus pops them by reading.

Around the two queues the block keeps the status the port needs. Two level flags follow the queue fill: the transmit queue has room, and the receive queue holds data. Four sticky event flags are set by events: a frame finished, the last frame of a queue finished, a received frame was lost because the receive queue was full, and an engine request found nothing to send while the port acts as a slave. Any of these can drive the interrupt line. The two level flags can be sent to DMA request lines instead of the interrupt. A bypass setting sends a bus write straight to a one-entry holding register that the engine reads ahead of any queuing, which gives the lowest possible latency.

Top module: `spiq_buffer`

## Requirements
- R1: A write to bus address 0 with bypass off appends {bit 31 = end-of-queue marker, bits DATA_W-1:0 = data} to the transmit queue (depth 5). While the queue holds data, `engTxValid` is 1 and `engTxData`/`engTxLast` show the oldest entry. A cycle with `engPop` high removes that entry, so entries leave in write order. A write to a full queue is dropped, and `txCount` reports the entries held (0 to 5).
- R2: `engRxPush` appends `engRxData` to the receive queue (depth 5). With `busAddr` = 0, `busRdData` shows the oldest entry zero-extended, and `busRdEn` pops it. A read of an empty queue returns 0 and changes nothing. `rxCount` reports the entries held.
- R3: `engRxPush` on a full receive queue with no pop in the same cycle sets the overflow flag (status bit 2) and drops the frame, leaving the stored entries unchanged. A push and a pop in the same cycle on a full queue both take effect and do not set the flag.
- R4: With `slaveMode` = 1, an `engPop` while `engTxValid` is 0 sets the underflow flag (status bit 3). In master mode the same stimulus leaves the flag clear.
- R5: Each `engRxPush` sets the frame-done flag (status bit 4). An `engRxPush` with `engRxLast` = 1 also sets the end-of-queue flag (status bit 5).
- R6: Status bits 2 to 5 are sticky. A bus write to address 1 clears each of them whose data bit is 1 and leaves the rest alone. When a clear and a set event for a flag fall in the same cycle, the flag is set afterwards.
- R7: The status word, read at address 1, has bit 0 = transmit queue not full, bit 1 = receive queue not empty, the `txCount` value from bit 8 and the `rxCount` value from bit 16.
- R8: `irq` is the OR of status bits 0 to 5, each gated by its own bit of `flagEn`. When `dmaSel` = 1, bits 0 and 1 are taken out of `irq`. `dmaTxReq` is then bit 0 AND `flagEn[0]`, and `dmaRxReq` is bit 1 AND `flagEn[1]`. Both DMA requests are 0 when `dmaSel` = 0.
- R9: With `bypassEn` = 1, a write to address 0 loads the holding register and leaves the transmit queue untouched. The engine then sees that word on `engTxValid`/`engTxData`/`engTxLast`, and one `engPop` empties the register.
- R10: After reset both counts are 0, all sticky flags are 0 and the status word reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slaveMode | input | 1 | 1 = slave operation (enables underflow detection) |
| bypassEn | input | 1 | 1 = writes go to the holding register, not the transmit queue |
| dmaSel | input | 1 | 1 = route fill/drain flags to DMA requests |
| flagEn | input | 6 | Per-flag enable, bit index = status bit index |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe (pops receive queue at address 0) |
| busAddr | input | 2 | 0 = data, 1 = status |
| busWrData | input | 32 | Bus write data |
| busRdData | output | 32 | Bus read data |
| engPop | input | 1 | Engine takes the next transmit word |
| engTxValid | output | 1 | A transmit word is available |
| engTxData | output | DATA_W | Transmit word |
| engTxLast | output | 1 | Transmit word ends the queue |
| engRxPush | input | 1 | Engine delivers a finished frame |
| engRxData | input | DATA_W | Received frame |
| engRxLast | input | 1 | Finished frame was the last of its queue |
| irq | output | 1 | Interrupt request |
| dmaTxReq | output | 1 | DMA request to refill transmit queue |
| dmaRxReq | output | 1 | DMA request to drain receive queue |
| txCount | output | 3 | Transmit queue entries |
| rxCount | output | 3 | Receive queue entries |

## Verification
The two functions that meet in one cycle are the bus clear of a sticky flag and the hardware event that sets the same flag. A second such pair is a receive push and a bus pop on a full receive queue. The bench fills the receive queue, then in a single cycle writes the overflow clear bit while the engine pushes another frame. The overflow flag must stay set and the stored frames must be unchanged. In a separate cycle it pops and pushes together, and then checks that the flag is still clear and that the new frame comes out last when the queue is drained in order.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic bypLoad;
    logic bypPop;
  } spiqStrobe_t;

  localparam int FLAG_FILL  = 0;
  localparam int FLAG_DRAIN = 1;
  localparam int FLAG_OVF   = 2;
  localparam int FLAG_UDF   = 3;
  localparam int FLAG_DONE  = 4;
  localparam int FLAG_EOQ   = 5;
  localparam int NUM_FLAGS  = 6;
  localparam int NUM_STICKY = 4;

  localparam int BUS_W     = 32;
  localparam int MARK_BIT  = 31;
  localparam int TXCNT_LSB = 8;
  localparam int RXCNT_LSB = 16;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int DEPTH = 5,
  parameter int WIDTH = 17
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           push,
  input  logic                           pop,
  input  logic [WIDTH-1:0]               wrData,
  output logic [WIDTH-1:0]               rdData,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign rdData = mem[rdPtr];

  // R1/R2: control never writes into a full queue unless it also frees a slot
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count != FULL_CNT || pop));
  // R2: control never pops an empty queue
  assert_no_underrun_R2: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
endmodule

// File: rtl/spiq_datapath.sv
module spiq_datapath
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  spiqStrobe_t                strobe,
  input  logic [DATA_W-1:0]          txWrData,
  input  logic                       txWrMark,
  input  logic                       bypassEn,
  input  logic [DATA_W-1:0]          rxWrData,
  output logic [$clog2(DEPTH+1)-1:0] txCount,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic [DATA_W-1:0]          rxHead,
  output logic                       bypValid,
  output logic                       engTxValid,
  output logic [DATA_W-1:0]          engTxData,
  output logic                       engTxLast
);
  localparam int TX_W = DATA_W + 1;

  logic [TX_W-1:0]   txHead;
  logic [DATA_W-1:0] bypData;
  logic              bypMark;

  spiq_fifo #(.DEPTH(DEPTH), .WIDTH(TX_W)) txFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pop(strobe.txPop),
    .wrData({txWrMark, txWrData}), .rdData(txHead), .count(txCount)
  );

  spiq_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) rxFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.rxPush), .pop(strobe.rxPop),
    .wrData(rxWrData), .rdData(rxHead), .count(rxCount)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bypValid <= 1'b0;
      bypData  <= '0;
      bypMark  <= 1'b0;
    end else if (strobe.bypLoad) begin
      bypValid <= 1'b1;
      bypData  <= txWrData;
      bypMark  <= txWrMark;
    end else if (strobe.bypPop) begin
      bypValid <= 1'b0;
    end
  end

  always_comb begin
    if (bypassEn) begin
      engTxValid = bypValid;
      engTxData  = bypData;
      engTxLast  = bypMark;
    end else begin
      engTxValid = (txCount != '0);
      engTxData  = txHead[DATA_W-1:0];
      engTxLast  = txHead[DATA_W];
    end
  end

  // R9: a bypass load is held for the engine on the following cycle
  assert_bypass_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bypLoad |=> (bypValid && bypData == $past(txWrData)));
endmodule

// File: rtl/spiq_control.sv
module spiq_control
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       slaveMode,
  input  logic                       bypassEn,
  input  logic                       dmaSel,
  input  logic [NUM_FLAGS-1:0]       flagEn,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [1:0]                 busAddr,
  input  logic [NUM_STICKY-1:0]      clrBits,
  input  logic                       engPop,
  input  logic                       engTxValid,
  input  logic                       engRxPush,
  input  logic                       engRxLast,
  input  logic                       bypValid,
  input  logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  input  logic [DATA_W-1:0]          rxHead,
  output spiqStrobe_t                strobe,
  output logic [BUS_W-1:0]           busRdData,
  output logic                       irq,
  output logic                       dmaTxReq,
  output logic                       dmaRxReq
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic                   wrData, wrStat, rdData;
  logic                   txFull, rxFull, rxEmpty;
  logic [NUM_STICKY-1:0]  sticky, setVec, clrVec;
  logic [NUM_FLAGS-1:0]   flagVec, irqMask;
  logic [BUS_W-1:0]       statWord;

  assign wrData  = busWrEn && (busAddr == ADDR_DATA);
  assign wrStat  = busWrEn && (busAddr == ADDR_STAT);
  assign rdData  = busRdEn && (busAddr == ADDR_DATA);
  assign txFull  = (txCount == FULL_CNT);
  assign rxFull  = (rxCount == FULL_CNT);
  assign rxEmpty = (rxCount == '0);

  always_comb begin
    strobe.txPop   = engPop && !bypassEn && (txCount != '0);
    strobe.txPush  = wrData && !bypassEn && (!txFull || strobe.txPop);
    strobe.rxPop   = rdData && !rxEmpty;
    strobe.rxPush  = engRxPush && (!rxFull || strobe.rxPop);
    strobe.bypLoad = wrData && bypassEn;
    strobe.bypPop  = engPop && bypassEn && bypValid;
  end

  // sticky events, index 0..3 maps to status bits FLAG_OVF..FLAG_EOQ
  assign setVec = {engRxPush && engRxLast,
                   engRxPush,
                   slaveMode && engPop && !engTxValid,
                   engRxPush && rxFull && !strobe.rxPop};
  assign clrVec = wrStat ? clrBits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) sticky <= '0;
    else       sticky <= (sticky & ~clrVec) | setVec;
  end

  assign flagVec = {sticky, !rxEmpty, !txFull};

  always_comb begin
    irqMask = flagEn;
    if (dmaSel) begin
      irqMask[FLAG_FILL]  = 1'b0;
      irqMask[FLAG_DRAIN] = 1'b0;
    end
  end

  assign irq      = |(flagVec & irqMask);
  assign dmaTxReq = dmaSel && flagEn[FLAG_FILL]  && flagVec[FLAG_FILL];
  assign dmaRxReq = dmaSel && flagEn[FLAG_DRAIN] && flagVec[FLAG_DRAIN];

  always_comb begin
    statWord = '0;
    statWord[NUM_FLAGS-1:0]        = flagVec;
    statWord[TXCNT_LSB +: CNT_W]   = txCount;
    statWord[RXCNT_LSB +: CNT_W]   = rxCount;
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_STAT) busRdData = statWord;
    else if (busAddr == ADDR_DATA && !rxEmpty) busRdData = BUS_W'(rxHead);
  end

  // R3: a full receive queue hit by a push without a pop raises overflow
  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxFull && !busRdEn) |=> flagVec[FLAG_OVF]);
  // R3: a dropped frame leaves the receive count unchanged
  assert_ovf_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxFull && !busRdEn) |=> (rxCount == FULL_CNT));
  // R4: a slave request with nothing to send raises underflow
  assert_udf_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && engPop && !engTxValid) |=> flagVec[FLAG_UDF]);
  // R6: an overflow flag survives every cycle without a clear bit for it
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (flagVec[FLAG_OVF] && !(busWrEn && busAddr == ADDR_STAT && clrBits[0]))
      |=> flagVec[FLAG_OVF]);
  // R8: the interrupt line only rises with an enabled flag behind it
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> |(flagVec & flagEn));
  // R8: DMA requests stay low when routing selects the interrupt
  assert_dma_route_R8: assert property (@(posedge clk) disable iff (!rstN)
    !dmaSel |-> !(dmaTxReq || dmaRxReq));
endmodule

// File: rtl/spiq_buffer.sv
module spiq_buffer
  import spiq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              bypassEn,
  input  logic              dmaSel,
  input  logic [5:0]        flagEn,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              engPop,
  output logic              engTxValid,
  output logic [DATA_W-1:0] engTxData,
  output logic              engTxLast,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  input  logic              engRxLast,
  output logic              irq,
  output logic              dmaTxReq,
  output logic              dmaRxReq,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);
  spiqStrobe_t       strobe;
  logic [DATA_W-1:0] rxHead;
  logic              bypValid;
  logic              unusedWr;

  assign unusedWr = ^busWrData;

  spiq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txWrData(busWrData[DATA_W-1:0]), .txWrMark(busWrData[MARK_BIT]),
    .bypassEn(bypassEn), .rxWrData(engRxData),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead), .bypValid(bypValid),
    .engTxValid(engTxValid), .engTxData(engTxData), .engTxLast(engTxLast)
  );

  spiq_control #(.DATA_W(DATA_W), .DEPTH(DEPTH)) control_i (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode), .bypassEn(bypassEn),
    .dmaSel(dmaSel), .flagEn(flagEn), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .clrBits(busWrData[FLAG_OVF +: NUM_STICKY]),
    .engPop(engPop), .engTxValid(engTxValid), .engRxPush(engRxPush),
    .engRxLast(engRxLast), .bypValid(bypValid), .txCount(txCount),
    .rxCount(rxCount), .rxHead(rxHead), .strobe(strobe),
    .busRdData(busRdData), .irq(irq), .dmaTxReq(dmaTxReq), .dmaRxReq(dmaRxReq)
  );
endmodule

// File: tb/spiq_buffer_tb.sv
module spiq_buffer_tb_top;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slaveMode = 1'b0, bypassEn = 1'b0, dmaSel = 1'b0;
  logic [5:0] flagEn = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [1:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic engPop = 1'b0, engRxPush = 1'b0, engRxLast = 1'b0;
  logic [DW-1:0] engRxData = '0;
  logic engTxValid, engTxLast, irq, dmaTxReq, dmaRxReq;
  logic [DW-1:0] engTxData;
  logic [2:0] txCount, rxCount;

  int nChecks = 0;
  int nFails = 0;
  int txModel = 0;
  logic [DW:0] expQ [$];

  always #10 clk = ~clk;

  spiq_buffer #(.DATA_W(DW), .DEPTH(5)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input bit fill, drain, ovf, udf, done, eoq,
                                     input int txc, input int rxc);
    logic [31:0] w = '0;
    w[0] = fill; w[1] = drain; w[2] = ovf; w[3] = udf; w[4] = done; w[5] = eoq;
    w[10:8] = 3'(txc);
    w[18:16] = 3'(rxc);
    return w;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic readStat(input string req, input logic [31:0] exp);
    busAddr = 2'd1;
    #1;
    chk(req, busRdData, exp);
  endtask

  // driver: pushes expected transmit words into the scoreboard
  task automatic txWrite(input logic [DW-1:0] d, input bit mark);
    busAddr = 2'd0;
    busWrData = {mark, 15'd0, d};
    busWrEn = 1'b1;
    if (bypassEn) expQ.push_back({mark, d});
    else if (txModel < 5) begin
      expQ.push_back({mark, d});
      txModel++;
    end
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic statWrite(input logic [31:0] d);
    busAddr = 2'd1;
    busWrData = d;
    busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic rxPush(input logic [DW-1:0] d, input bit last);
    engRxData = d;
    engRxLast = last;
    engRxPush = 1'b1;
    tick();
    engRxPush = 1'b0;
    engRxLast = 1'b0;
  endtask

  task automatic rxRead(input string req, input logic [31:0] exp);
    busAddr = 2'd0;
    busRdEn = 1'b1;
    #1;
    chk(req, busRdData, exp);
    tick();
    busRdEn = 1'b0;
  endtask

  // monitor: compares every word the engine takes against the scoreboard
  always @(negedge clk) begin
    if (rstN && engPop && engTxValid) begin
      if (expQ.size() == 0) chk("R1 unexpected tx word", {15'd0, engTxLast, engTxData}, 32'hDEAD);
      else begin
        logic [DW:0] e;
        e = expQ.pop_front();
        chk("R1/R9 tx order", {15'd0, engTxLast, engTxData}, {15'd0, e});
        if (!bypassEn) txModel--;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R10 reset state
    chk("R10 txCount", 32'(txCount), 0);
    chk("R10 rxCount", 32'(rxCount), 0);
    readStat("R10 status", st(1,0,0,0,0,0,0,0));
    chk("R10 irq", 32'(irq), 0);

    // R1 fill transmit queue, sixth write dropped
    for (int i = 0; i < 6; i++) txWrite(DW'(16'h100 + i), i == 4);
    chk("R1 txCount full", 32'(txCount), 5);
    readStat("R7 fill clear when full", st(0,0,0,0,0,0,5,0));
    engPop = 1'b1;
    repeat (6) tick();   // five words plus one pop on empty in master mode
    engPop = 1'b0;
    chk("R1 scoreboard drained", 32'(expQ.size()), 0);
    chk("R1 txCount empty", 32'(txCount), 0);
    readStat("R4 master pop on empty", st(1,0,0,0,0,0,0,0));

    // R2/R3/R5 receive queue and overflow
    for (int i = 0; i < 5; i++) rxPush(DW'(16'h20 + i), 1'b0);
    readStat("R5/R7 rx full", st(1,1,0,0,1,0,0,5));
    rxPush(16'h99, 1'b0);
    readStat("R3 overflow set", st(1,1,1,0,1,0,0,5));
    for (int i = 0; i < 5; i++) rxRead("R3 contents kept", 32'h20 + i);
    rxRead("R2 empty read", 32'h0);
    chk("R2 rxCount empty", 32'(rxCount), 0);
    statWrite(32'h4);
    readStat("R6 clear ovf only", st(1,0,0,0,1,0,0,0));
    statWrite(32'h0);
    readStat("R6 zero write", st(1,0,0,0,1,0,0,0));
    statWrite(32'h30);
    readStat("R6 clear done", st(1,0,0,0,0,0,0,0));

    // same-cycle cases
    for (int i = 0; i < 5; i++) rxPush(DW'(16'h40 + i), 1'b0);
    busAddr = 2'd0; busRdEn = 1'b1;
    engRxData = 16'h77; engRxPush = 1'b1;
    #1;
    chk("R2 head before push+pop", busRdData, 32'h40);
    tick();
    busRdEn = 1'b0; engRxPush = 1'b0;
    readStat("R3 push+pop on full no ovf", st(1,1,0,0,1,0,0,5));
    busAddr = 2'd1; busWrData = 32'h4; busWrEn = 1'b1;
    engRxData = 16'h88; engRxPush = 1'b1;
    tick();
    busWrEn = 1'b0; engRxPush = 1'b0;
    readStat("R6 set wins over clear", st(1,1,1,0,1,0,0,5));
    statWrite(32'h34);
    readStat("R6 clear ovf done", st(1,1,0,0,0,0,0,5));
    for (int i = 1; i < 5; i++) rxRead("R3 order after push+pop", 32'h40 + i);
    rxRead("R3 pushed frame last", 32'h77);
    rxPush(16'h55, 1'b1);
    readStat("R5 end of queue", st(1,1,0,0,1,1,0,1));
    rxRead("R2 last frame", 32'h55);
    statWrite(32'h30);

    // R4 slave underflow
    slaveMode = 1'b1;
    engPop = 1'b1;
    tick();
    engPop = 1'b0;
    readStat("R4 slave underflow", st(1,0,0,1,0,0,0,0));

    // R8 interrupt and DMA routing
    flagEn = 6'b001000; #1;
    chk("R8 irq udf", 32'(irq), 1);
    statWrite(32'h8);
    #1;
    chk("R8 irq after clear", 32'(irq), 0);
    flagEn = 6'b000001; #1;
    chk("R8 irq fill", 32'(irq), 1);
    chk("R8 no dma", 32'(dmaTxReq), 0);
    dmaSel = 1'b1; #1;
    chk("R8 fill to dma irq", 32'(irq), 0);
    chk("R8 dmaTxReq", 32'(dmaTxReq), 1);
    rxPush(16'h66, 1'b0);
    flagEn = 6'b000010; #1;
    chk("R8 dmaRxReq", 32'(dmaRxReq), 1);
    chk("R8 irq drain routed", 32'(irq), 0);
    flagEn = 6'b010010; #1;
    chk("R8 irq done", 32'(irq), 1);
    flagEn = '0; dmaSel = 1'b0;
    rxRead("R2 drain", 32'h66);

    // R9 bypass
    slaveMode = 1'b0;
    bypassEn = 1'b1;
    txWrite(16'hABC, 1'b1);
    chk("R9 queue untouched", 32'(txCount), 0);
    #1;
    chk("R9 bypass valid", 32'(engTxValid), 1);
    engPop = 1'b1;
    tick();
    engPop = 1'b0;
    #1;
    chk("R9 bypass consumed", 32'(engTxValid), 0);
    chk("R9 scoreboard empty", 32'(expQ.size()), 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule